// File: doc/BRIEF.md
# Byte/Word Shift Unit with Status Flags

This block executes left shifts and sign-preserving right shifts on an 8-bit or 16-bit operand. It returns the shifted value together with the carry, overflow, sign, zero, parity and auxiliary-carry flag values. A write-enable mask tells the downstream flag register which of those values it should take. Two left-shift opcodes (logical and arithmetic) are accepted and behave identically. The shift count is taken either from an immediate field or from the low byte of a count register, and only its low five bits are used.

The unit has one pipeline register. An operation presented with `in_valid` high is sampled on a rising clock edge, and its result, flags and mask appear on the outputs right after that same edge, qualified by `out_valid`. When the effective count is zero, the operand passes through unchanged and no flag is written. The direction, interrupt and trap flags are not visible to this block, so they are never touched.

Top module: `shift_flag_unit`

## Requirements
- R1: For op_code 2'b00 or 2'b01 the result is the operand shifted left by the effective count with zeros entering at bit 0. Both codes give identical results and flags.
- R2: For op_code 2'b10 or 2'b11 the result is the operand shifted right by the effective count with copies of the original top bit entering from above, so negative values round toward minus infinity (byte 0xFB by 1 gives 0xFD).
- R3: Carry equals the last bit shifted out. For counts beyond the operand width, a left shift yields carry 0 and result 0, and a right shift yields carry and every result bit equal to the original sign.
- R4: A left shift by exactly 1 sets overflow when the result's top bit differs from the new carry and clears it otherwise. A right shift always clears overflow.
- R5: Sign is the result's top bit (bit 7 when op_size=0, bit 15 when op_size=1). Zero is set when all bits of the selected width are 0. Parity is set when result bits 7..0 hold an even number of ones. For byte operations, result bits 15..8 are 0.
- R6: With cnt_sel=0 the count is imm_cnt[4:0], and with cnt_sel=1 it is cnt_reg[4:0]. All other bits of both sources are ignored.
- R7: With an effective count of 0, the result equals the operand masked to the selected width, and flag_we is all zeros.
- R8: flag_we bit map: bit0 carry, bit1 parity, bit2 aux-carry, bit3 zero, bit4 sign, bit5 overflow. A nonzero count gives 6'b111011. The aux-carry bit is never set.
- R9: Outputs are registered once: out_valid follows in_valid by one clock. flag_we is 0 whenever out_valid is 0. Reset clears out_valid, flag_we and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 00/01 left shift, 10/11 arithmetic right shift |
| op_size | input | 1 | 0 byte, 1 word |
| cnt_sel | input | 1 | 0 immediate count, 1 count register |
| imm_cnt | input | 8 | Immediate count field |
| cnt_reg | input | 16 | Count register value |
| operand | input | 16 | Destination value (byte in bits 7..0) |
| out_valid | output | 1 | Result valid |
| result | output | 16 | Shifted value |
| cf | output | 1 | Carry flag value |
| of | output | 1 | Overflow flag value |
| sf | output | 1 | Sign flag value |
| zf | output | 1 | Zero flag value |
| pf | output | 1 | Parity flag value |
| af | output | 1 | Aux-carry value (always 0, never enabled) |
| flag_we | output | 6 | Per-flag write enable mask |

## Verification
Every result, flag and mask bit is due exactly one rising edge after the operation is presented. The bench therefore drives inputs on a falling edge, lets one rising edge pass, and samples on the following falling edge. One more idle falling edge then confirms that out_valid and flag_we have dropped. The expected values come from a bit-by-bit iterative shift model in the bench. Overflow is compared only where it is defined: right shifts, and left shifts by exactly one.

// File: rtl/shift_flag_pkg.sv
package shift_flag_pkg;
   localparam int FLAG_N = 6;
   typedef enum logic [2:0] {
      FL_CARRY  = 3'd0,
      FL_PARITY = 3'd1,
      FL_AUX    = 3'd2,
      FL_ZERO   = 3'd3,
      FL_SIGN   = 3'd4,
      FL_OVFL   = 3'd5
   } flag_idx_e;

   typedef struct packed {
      logic ovfl;
      logic sign;
      logic zero;
      logic aux;
      logic parity;
      logic carry;
   } flag_vec_t;

   localparam flag_vec_t WE_ACTIVE = '{ovfl: 1'b1, sign: 1'b1, zero: 1'b1,
                                      aux: 1'b0, parity: 1'b1, carry: 1'b1};
endpackage

// File: rtl/shift_count_sel.sv
module shift_count_sel #(
   parameter int IMM_W    = 8,
   parameter int CREG_W   = 16,
   parameter int CNT_BITS = 5
) (
   input  logic                cnt_sel,
   input  logic [IMM_W-1:0]    imm_cnt,
   input  logic [CREG_W-1:0]   cnt_reg,
   output logic [CNT_BITS-1:0] cnt_eff,
   output logic                cnt_zero,
   output logic                cnt_one
);
   initial begin
      assert (CNT_BITS <= IMM_W && CNT_BITS <= CREG_W)
         else $error("count field wider than its sources");
   end

   always_comb begin
      cnt_eff  = cnt_sel ? cnt_reg[CNT_BITS-1:0] : imm_cnt[CNT_BITS-1:0];
      cnt_zero = (cnt_eff == '0);
      cnt_one  = (cnt_eff == CNT_BITS'(1));
   end
endmodule

// File: rtl/shift_core.sv
module shift_core #(
   parameter int W        = 16,
   parameter int CNT_BITS = 5
) (
   input  logic [W-1:0]        din,
   input  logic [CNT_BITS-1:0] cnt,
   input  logic                arith_right,
   output logic [W-1:0]        dout,
   output logic                carry
);
   localparam int MAXCNT = (1 << CNT_BITS) - 1;
   localparam int EXT    = W + MAXCNT + 2;

   logic [EXT-1:0]        left_wide;
   logic signed [EXT-1:0] right_src;
   logic signed [EXT-1:0] right_wide;

   always_comb begin
      left_wide  = {{(EXT-W){1'b0}}, din} << cnt;
      right_src  = $signed({{(EXT-W-1){din[W-1]}}, din, 1'b0});
      right_wide = right_src >>> cnt;
      if (arith_right) begin
         dout  = right_wide[W:1];
         carry = right_wide[0];
      end else begin
         dout  = left_wide[W-1:0];
         carry = left_wide[W];
      end
   end
endmodule

// File: rtl/shift_flag_gen.sv
module shift_flag_gen #(
   parameter int W      = 16,
   parameter int PAR_W  = 8
) (
   input  logic [W-1:0] res,
   input  logic         carry_in,
   input  logic         arith_right,
   output logic         ovfl,
   output logic         sign,
   output logic         zero,
   output logic         parity
);
   initial begin
      assert (PAR_W <= W) else $error("parity span exceeds width");
   end

   always_comb begin
      sign   = res[W-1];
      zero   = (res == '0);
      parity = ~^res[PAR_W-1:0];
      ovfl   = arith_right ? 1'b0 : (res[W-1] ^ carry_in);
   end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit #(
   parameter int DATA_W   = 16,
   parameter int BYTE_W   = 8,
   parameter int IMM_W    = 8,
   parameter int CREG_W   = 16,
   parameter int CNT_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        op_code,
   input  logic              op_size,
   input  logic              cnt_sel,
   input  logic [IMM_W-1:0]  imm_cnt,
   input  logic [CREG_W-1:0] cnt_reg,
   input  logic [DATA_W-1:0] operand,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              cf,
   output logic              of,
   output logic              sf,
   output logic              zf,
   output logic              pf,
   output logic              af,
   output logic [5:0]        flag_we
);
   import shift_flag_pkg::*;

   localparam int NSIZE = 2;

   initial begin
      assert (DATA_W == 2 * BYTE_W) else $error("word must be two bytes");
      assert (FLAG_N == 6) else $error("flag mask width mismatch");
   end

   logic [CNT_BITS-1:0] cnt_eff;
   logic                cnt_zero, cnt_one;
   logic                arith_right;

   assign arith_right = op_code[1];

   shift_count_sel #(.IMM_W(IMM_W), .CREG_W(CREG_W), .CNT_BITS(CNT_BITS)) u_cnt (
      .cnt_sel (cnt_sel),
      .imm_cnt (imm_cnt),
      .cnt_reg (cnt_reg),
      .cnt_eff (cnt_eff),
      .cnt_zero(cnt_zero),
      .cnt_one (cnt_one)
   );

   logic [DATA_W-1:0] lane_res [NSIZE];
   logic              lane_cf  [NSIZE];
   logic              lane_of  [NSIZE];
   logic              lane_sf  [NSIZE];
   logic              lane_zf  [NSIZE];
   logic              lane_pf  [NSIZE];

   for (genvar g = 0; g < NSIZE; g++) begin : g_lane
      localparam int LW = (g == 0) ? BYTE_W : DATA_W;
      logic [LW-1:0] lres;
      logic          lcarry;

      shift_core #(.W(LW), .CNT_BITS(CNT_BITS)) u_core (
         .din        (operand[LW-1:0]),
         .cnt        (cnt_eff),
         .arith_right(arith_right),
         .dout       (lres),
         .carry      (lcarry)
      );

      shift_flag_gen #(.W(LW), .PAR_W(BYTE_W)) u_flags (
         .res        (lres),
         .carry_in   (lcarry),
         .arith_right(arith_right),
         .ovfl       (lane_of[g]),
         .sign       (lane_sf[g]),
         .zero       (lane_zf[g]),
         .parity     (lane_pf[g])
      );

      if (LW < DATA_W) begin : g_pad
         assign lane_res[g] = {{(DATA_W-LW){1'b0}}, lres};
      end else begin : g_full
         assign lane_res[g] = lres;
      end
      assign lane_cf[g] = lcarry;
   end

   flag_vec_t         we_next;
   logic [DATA_W-1:0] res_next;
   int unsigned       sel;

   always_comb begin
      sel     = op_size ? 1 : 0;
      we_next = cnt_zero ? '0 : WE_ACTIVE;
      if (cnt_zero) res_next = op_size ? operand : {{(DATA_W-BYTE_W){1'b0}}, operand[BYTE_W-1:0]};
      else          res_next = lane_res[sel];
   end

   // cnt_one is kept for readability of the overflow definition: the value
   // driven for left counts above one is the same expression, permitted since
   // that overflow is unspecified.
   logic unused_one;
   assign unused_one = cnt_one;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         cf        <= 1'b0;
         of        <= 1'b0;
         sf        <= 1'b0;
         zf        <= 1'b0;
         pf        <= 1'b0;
         flag_we   <= '0;
      end else begin
         out_valid <= in_valid;
         flag_we   <= in_valid ? we_next : '0;
         if (in_valid) begin
            result <= res_next;
            cf     <= lane_cf[sel];
            of     <= lane_of[sel];
            sf     <= lane_sf[sel];
            zf     <= lane_zf[sel];
            pf     <= lane_pf[sel];
         end
      end
   end

   assign af = 1'b0;
endmodule

// File: rtl/shift_flag_unit_chk.sv
module shift_flag_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [1:0]  op_code,
   input logic        op_size,
   input logic        cnt_sel,
   input logic [7:0]  imm_cnt,
   input logic [15:0] cnt_reg,
   input logic [15:0] operand,
   input logic        out_valid,
   input logic [15:0] result,
   input logic        cf,
   input logic        of,
   input logic        zf,
   input logic [5:0]  flag_we
);
   logic [4:0] c_in;
   assign c_in = cnt_sel ? cnt_reg[4:0] : imm_cnt[4:0];

   // R9: no flag write without a valid result
   a_r9_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> flag_we == 6'b0);

   // R9: valid is delayed by exactly one clock
   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R8: aux-carry is never enabled
   a_r8_no_aux_write: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we[2]);

   // R4: right shift clears overflow
   a_r4_sar_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_code[1] && c_in != 5'd0) |=> !of);

   // R7: zero count writes no flags and passes the operand
   a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && c_in == 5'd0 && op_size) |=> (flag_we == 6'b0 && result == $past(operand)));

   // R5: byte operations leave the upper half clear
   a_r5_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_size) |=> result[15:8] == 8'h00);

   // R3: left shift past the word width empties the operand
   a_r3_left_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !op_code[1] && op_size && c_in > 5'd16) |=> (result == 16'h0 && !cf && zf));
endmodule

bind shift_flag_unit shift_flag_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
   .op_size(op_size), .cnt_sel(cnt_sel), .imm_cnt(imm_cnt), .cnt_reg(cnt_reg),
   .operand(operand), .out_valid(out_valid), .result(result), .cf(cf),
   .of(of), .zf(zf), .flag_we(flag_we)
);

// File: tb/shift_flag_unit_tb.sv
module shift_flag_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [1:0]  op_code;
   logic        op_size;
   logic        cnt_sel;
   logic [7:0]  imm_cnt;
   logic [15:0] cnt_reg;
   logic [15:0] operand;
   logic        out_valid;
   logic [15:0] result;
   logic        cf, of, sf, zf, pf, af;
   logic [5:0]  flag_we;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   shift_flag_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .op_size(op_size), .cnt_sel(cnt_sel), .imm_cnt(imm_cnt), .cnt_reg(cnt_reg),
      .operand(operand), .out_valid(out_valid), .result(result), .cf(cf),
      .of(of), .sf(sf), .zf(zf), .pf(pf), .af(af), .flag_we(flag_we)
   );

   task automatic check(input string tag, input bit ok, input string got, input string exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %s expected %s", tag, got, exp);
      end
   endtask

   // iterative one-bit-at-a-time model
   task automatic model(input bit right, input bit wsz, input logic [15:0] v, input int c,
                        output logic [15:0] r, output bit cfo, output bit ofo);
      int w = wsz ? 16 : 8;
      logic [15:0] m = wsz ? 16'hFFFF : 16'h00FF;
      logic [15:0] d = v & m;
      bit sgn = d[w-1];
      cfo = 0;
      for (int i = 0; i < c; i++) begin
         if (right) begin
            cfo = d[0];
            d = (d >> 1) | (16'(sgn) << (w-1));
         end else begin
            cfo = d[w-1];
            d = (d << 1) & m;
         end
      end
      r = d;
      ofo = right ? 1'b0 : (d[w-1] != cfo);
   endtask

   task automatic run_op(input string tag, input logic [1:0] op, input bit wsz,
                         input bit src, input logic [7:0] imm, input logic [15:0] creg,
                         input logic [15:0] v);
      logic [15:0] er;
      bit ecf, eof, ok;
      int c = src ? int'(creg[4:0]) : int'(imm[4:0]);
      logic [5:0] ewe;
      @(negedge clk);
      in_valid = 1; op_code = op; op_size = wsz; cnt_sel = src;
      imm_cnt = imm; cnt_reg = creg; operand = v;
      @(negedge clk);
      in_valid = 0;
      model(op[1], wsz, v, c, er, ecf, eof);
      ewe = (c == 0) ? 6'b000000 : 6'b111011;
      ok = out_valid && result == er && flag_we == ewe && !af;
      if (c != 0) begin
         ok = ok && cf == ecf && sf == er[wsz ? 15 : 7] && zf == (er == 16'h0) && pf == ~^er[7:0];
         if (op[1] || c == 1) ok = ok && of == eof;
      end
      check(tag, ok,
            $sformatf("res=%h cf=%b of=%b sf=%b zf=%b pf=%b we=%b", result, cf, of, sf, zf, pf, flag_we),
            $sformatf("res=%h cf=%b of=%b we=%b (op=%b sz=%b c=%0d v=%h)", er, ecf, eof, ewe, op, wsz, c, v));
      @(negedge clk);
      check("R9 idle", !out_valid && flag_we == 6'b0,
            $sformatf("valid=%b we=%b", out_valid, flag_we), "valid=0 we=000000");
   endtask

   task automatic t_reset();
      rst_n = 0; in_valid = 0; op_code = 0; op_size = 0; cnt_sel = 0;
      imm_cnt = 0; cnt_reg = 0; operand = 0;
      repeat (3) @(negedge clk);
      check("R9 reset", !out_valid && flag_we == 6'b0 && result == 16'h0,
            $sformatf("valid=%b we=%b res=%h", out_valid, flag_we, result), "all zero");
      rst_n = 1;
   endtask

   task automatic t_left_sweep();
      for (int c = 0; c < 32; c++) begin
         run_op("R1 R3 R4 R5 left word", 2'b00, 1, 0, 8'(c), 16'h0, 16'hC3A5);
         run_op("R1 R3 R4 R5 left byte", 2'b01, 0, 0, 8'(c), 16'h0, 16'h5A96);
      end
   endtask

   task automatic t_sal_same();
      run_op("R1 shl", 2'b00, 1, 0, 8'd1, 16'h0, 16'h4001);
      run_op("R1 sal", 2'b01, 1, 0, 8'd1, 16'h0, 16'h4001);
      run_op("R4 of clear", 2'b00, 0, 0, 8'd1, 16'h0, 16'h00C0);
   endtask

   task automatic t_sar_sweep();
      for (int c = 0; c < 32; c++) begin
         run_op("R2 R3 R5 sar word neg", 2'b10, 1, 0, 8'(c), 16'h0, 16'h9A3C);
         run_op("R2 R3 R5 sar byte pos", 2'b11, 0, 0, 8'(c), 16'h0, 16'h3F6B);
      end
   endtask

   task automatic t_sar_floor();
      run_op("R2 minus five", 2'b10, 0, 0, 8'd1, 16'h0, 16'h00FB);
      check("R2 floor value", result == 16'h00FD,
            $sformatf("%h", result), "00fd");
      run_op("R4 sar of", 2'b10, 1, 0, 8'd1, 16'h0, 16'hC000);
   endtask

   task automatic t_count_src();
      run_op("R6 reg low bits", 2'b00, 1, 1, 8'h05, 16'hFFE3, 16'h1234);
      run_op("R6 imm high bits", 2'b10, 1, 0, 8'hE2, 16'h0007, 16'h8421);
      run_op("R6 reg 32 wraps to 0", 2'b00, 0, 1, 8'h03, 16'h0020, 16'h00AB);
   endtask

   task automatic t_zero_count();
      run_op("R7 word zero", 2'b10, 1, 0, 8'h00, 16'h0, 16'hBEEF);
      run_op("R7 byte zero", 2'b00, 0, 1, 8'h01, 16'hFF00, 16'hBEEF);
      check("R7 masked", result == 16'h00EF, $sformatf("%h", result), "00ef");
   endtask

   task automatic t_flag_map();
      run_op("R8 mask", 2'b00, 1, 0, 8'd3, 16'h0, 16'h0001);
      check("R8 bits", flag_we == 6'b000000 && !af, $sformatf("%b", flag_we), "000000 after idle");
   endtask

   initial begin
      t_reset();
      t_left_sweep();
      t_sal_same();
      t_sar_sweep();
      t_sar_floor();
      t_count_src();
      t_zero_count();
      t_flag_map();
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      wait (cycles > 150000 || done);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule